// File: doc/BRIEF.md
# Two-Way Sample Output Demultiplexer

This block sits behind a converter core. On every input clock it takes one signed raw sample and clamps it to an 8-bit offset-binary code. A sample beyond either rail sets an over-range flag. Consecutive codes are then split across two parallel output buses. The early bus carries the older sample of each pair and the late bus carries the newer one. Both buses change on the same clock edge, once every two input clocks.

A companion data clock is generated for the receiver. In single-rate mode it runs at half the input clock, and an edge-select input chooses whether the bus changes on its rising or its falling edge. In double-rate mode it runs at a quarter of the input clock, and each of its edges marks one pair. A data-clock reset input holds the divider at a fixed phase so that several devices can be aligned. While calibration runs, the data clock is held low and data keeps flowing.

Top module: `sdmx_top`

## Requirements
- R1: A raw input r (two's complement, RAW_W bits) is converted to code r+128 when -128 <= r <= 127; r > 127 yields code 255 and r < -128 yields code 0.
- R2: The over-range flag of a sample is 1 exactly when that sample was clamped (r > 127 or r < -128). It appears on early_ovr or late_ovr together with that sample's code.
- R3: The first clock edge that samples dclk_rst low is divider phase 0. The sample captured one edge before a phase-0 edge goes to early_code and the sample captured at the phase-0 edge goes to late_code. Both are updated at the following edge, and the pattern repeats every two edges.
- R4: early_code, late_code and both flags stay unchanged on edges between pair updates.
- R5: In single-rate mode (ddr_en=0) dclk toggles on every edge. With edge_sel=1 it goes high on the edge that updates the buses; with edge_sel=0 it goes low on that edge.
- R6: In double-rate mode (ddr_en=1) dclk has a period of four input clocks. It goes high on the edge that launches the first pair after divider phase 0 and goes low on the edge that launches the next pair.
- R7: While dclk_rst is high the divider is held at phase 0 and no pair is launched. dclk sits at its idle level: 0 in double-rate mode, and the inverse of edge_sel in single-rate mode.
- R8: cal_busy high forces dclk to 0 from the next edge, while the bus pairing continues unchanged.
- R9: After reset, both codes, both flags and dclk are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | RAW_W | Signed raw sample from the core |
| ddr_en | input | 1 | 1 selects double-rate data clock |
| edge_sel | input | 1 | Single-rate launch edge: 1 rising, 0 falling |
| dclk_rst | input | 1 | Holds the data-clock divider at phase 0 |
| cal_busy | input | 1 | Calibration running; silences dclk |
| early_code | output | 8 | Older code of each pair |
| late_code | output | 8 | Newer code of each pair |
| early_ovr | output | 1 | Over-range flag of early_code |
| late_ovr | output | 1 | Over-range flag of late_code |
| dclk | output | 1 | Output data clock |

## Verification
Each run restarts the divider with a known pre-release sample, so the expected pairing is fixed. Ascending ramps that straddle +127/+128 and -128/-129 show whether the clamp boundaries are exact. They also show whether the flag moves with its own sample rather than with the neighbouring one. A coarse stride sweeping from far below to far above the rails separates a saturating clamp from a wrapping one. Runs under each edge-select value, in double-rate mode and with calibration active show whether the data-clock phase is tied to the bus update edge, and whether silencing the clock leaves the data path intact.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;

    localparam int CODE_W = 8;
    localparam int PH_W   = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ovr;
    } smp_t;

    // Saturating conversion of a signed value to offset binary
    function automatic smp_t to_code(input int v);
        smp_t s;
        int   hi;
        int   lo;
        hi = (1 << (CODE_W - 1)) - 1;
        lo = -(1 << (CODE_W - 1));
        if (v > hi) begin
            s.code = '1;
            s.ovr  = 1'b1;
        end else if (v < lo) begin
            s.code = '0;
            s.ovr  = 1'b1;
        end else begin
            s.code = CODE_W'(v - lo);
            s.ovr  = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/sdmx_clamp.sv
module sdmx_clamp #(
    parameter int RAW_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [RAW_W-1:0] raw,
    output sdmx_pkg::smp_t          smp
);
    import sdmx_pkg::*;

    int raw_int;
    always_comb raw_int = int'(raw);

    always_ff @(posedge clk) begin
        if (rst) smp <= '0;
        else     smp <= to_code(raw_int);
    end

    AST_OVR_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
        smp.ovr |-> (smp.code == '0 || smp.code == '1)); // R2

endmodule

// File: rtl/sdmx_clkgen.sv
module sdmx_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic ddr_en,
    input  logic edge_sel,
    input  logic div_rst,
    input  logic cal_busy,
    output logic launch,
    output logic dclk
);
    import sdmx_pkg::*;

    localparam logic [PH_W-1:0] PH_RISE = PH_W'(1);
    localparam logic [PH_W-1:0] PH_FALL = PH_W'(3);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || div_rst) ph <= '0;
        else                ph <= ph + 1'b1;
    end

    assign launch = ph[0];

    always_ff @(posedge clk) begin
        if (rst || cal_busy)   dclk <= 1'b0;
        else if (div_rst)      dclk <= ddr_en ? 1'b0 : ~edge_sel;
        else if (!ddr_en)      dclk <= ph[0] ? edge_sel : ~edge_sel;
        else if (ph == PH_RISE) dclk <= 1'b1;
        else if (ph == PH_FALL) dclk <= 1'b0;
    end

    logic sdr_run;
    assign sdr_run = !rst && !ddr_en && !cal_busy && !div_rst;

    AST_CAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        cal_busy |=> !dclk); // R8

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        div_rst |=> !launch); // R7

    AST_SDR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ($past(sdr_run) && $past(sdr_run, 2) && $past(edge_sel) == $past(edge_sel, 2))
        |-> dclk != $past(dclk)); // R5

endmodule

// File: rtl/sdmx_pair.sv
module sdmx_pair (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch,
    input  sdmx_pkg::smp_t cur,
    output sdmx_pkg::smp_t early,
    output sdmx_pkg::smp_t late
);
    import sdmx_pkg::*;

    smp_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            early <= '0;
            late  <= '0;
        end else if (launch) begin
            early <= held;
            late  <= cur;
        end else begin
            held  <= cur;
        end
    end

    AST_PAIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !launch |=> ($stable(early) && $stable(late))); // R4

endmodule

// File: rtl/sdmx_top.sv
module sdmx_top #(
    parameter int RAW_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [RAW_W-1:0] raw_in,
    input  logic                    ddr_en,
    input  logic                    edge_sel,
    input  logic                    dclk_rst,
    input  logic                    cal_busy,
    output logic [7:0]              early_code,
    output logic [7:0]              late_code,
    output logic                    early_ovr,
    output logic                    late_ovr,
    output logic                    dclk
);
    import sdmx_pkg::*;

    smp_t cur_smp;
    smp_t early_smp;
    smp_t late_smp;
    logic launch;

    sdmx_clamp #(.RAW_W(RAW_W)) u_clamp (
        .clk (clk),
        .rst (rst),
        .raw (raw_in),
        .smp (cur_smp)
    );

    sdmx_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .ddr_en   (ddr_en),
        .edge_sel (edge_sel),
        .div_rst  (dclk_rst),
        .cal_busy (cal_busy),
        .launch   (launch),
        .dclk     (dclk)
    );

    sdmx_pair u_pair (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .cur    (cur_smp),
        .early  (early_smp),
        .late   (late_smp)
    );

    assign early_code = early_smp.code;
    assign late_code  = late_smp.code;
    assign early_ovr  = early_smp.ovr;
    assign late_ovr   = late_smp.ovr;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (early_code == 8'd0 && late_code == 8'd0 && !dclk)); // R9

endmodule

// File: tb/sdmx_top_tb.sv
module sdmx_top_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [9:0] raw_in = '0;
    logic              ddr_en = 1'b0;
    logic              edge_sel = 1'b1;
    logic              dclk_rst = 1'b0;
    logic              cal_busy = 1'b0;
    logic [7:0]        early_code;
    logic [7:0]        late_code;
    logic              early_ovr;
    logic              late_ovr;
    logic              dclk;

    int total = 0;
    int bad = 0;
    int arr[14];

    always #2.5 clk = ~clk;

    sdmx_top #(.RAW_W(10)) u_dut (
        .clk(clk), .rst(rst), .raw_in(raw_in), .ddr_en(ddr_en),
        .edge_sel(edge_sel), .dclk_rst(dclk_rst), .cal_busy(cal_busy),
        .early_code(early_code), .late_code(late_code),
        .early_ovr(early_ovr), .late_ovr(late_ovr), .dclk(dclk)
    );

    function automatic int exp_code(input int r);
        if (r > 127)  return 255;
        if (r < -128) return 0;
        return r + 128;
    endfunction

    function automatic int exp_ovr(input int r);
        return (r > 127 || r < -128) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "early_code", int'(early_code), 0);
        chk("R9", "late_code", int'(late_code), 0);
        chk("R9", "ovr", int'({early_ovr, late_ovr}), 0);
        chk("R9", "dclk", int'(dclk), 0);
        rst = 1'b0;
    endtask

    // Restart the divider, stream arr[] and check pairing, flags and dclk
    task automatic run_stream(input string name, input bit ddr, input bit es,
                              input bit cal, input int start, input int stride);
        int idle;
        for (int i = 0; i < 14; i++) arr[i] = start + stride * i;
        @(negedge clk);
        ddr_en = ddr; edge_sel = es; cal_busy = cal; dclk_rst = 1'b1; raw_in = '0;
        @(negedge clk);
        raw_in = 10'(arr[0]);
        idle = cal ? 0 : (ddr ? 0 : int'(!es));
        chk("R7", {name, " idle dclk"}, int'(dclk), idle);
        @(negedge clk);
        dclk_rst = 1'b0;
        raw_in = 10'(arr[1]);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                int ke;
                int ed;
                ke = (k % 2 == 0) ? k : k - 1;
                // R3 pairing, R4 hold between updates, R1 code values
                chk("R3", {name, " early_code"}, int'(early_code), exp_code(arr[ke-2]));
                chk("R3", {name, " late_code"}, int'(late_code), exp_code(arr[ke-1]));
                chk("R2", {name, " early_ovr"}, int'(early_ovr), exp_ovr(arr[ke-2]));
                chk("R2", {name, " late_ovr"}, int'(late_ovr), exp_ovr(arr[ke-1]));
            end
            begin
                int j;
                int ed;
                j = k - 1;
                if (cal)      ed = 0;
                else if (ddr) ed = ((j + 1) >> 1) & 1;
                else          ed = (k % 2 == 0) ? int'(es) : int'(!es);
                chk(cal ? "R8" : (ddr ? "R6" : "R5"), {name, " dclk"}, int'(dclk), ed);
            end
            raw_in = 10'(arr[k+1]);
        end
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_stream("R1 upper rail", 1'b0, 1'b1, 1'b0, 121, 1);
        run_stream("R1 lower rail", 1'b0, 1'b0, 1'b0, -134, 1);
        run_stream("R2 wide sweep", 1'b0, 1'b1, 1'b0, -300, 55);
        run_stream("R6 ddr ramp", 1'b1, 1'b0, 1'b0, 100, -37);
        run_stream("R8 calibration", 1'b0, 1'b1, 1'b1, -20, 9);
        run_stream("R7 restart ddr", 1'b1, 1'b1, 1'b0, 5, 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule